// File: doc/BRIEF.md
# Identity-Selected Custom Opcode Decode Router

This block sits in an instruction decoder. It chooses which of several extension decode engines receives the instructions in the custom opcode space. Those instructions all share one encoding. The choice depends on a writable identity held as a (vendor id, architecture id) pair.

The identity has write-any-read-legal behaviour. A write of a tuple found in the supported table selects that table entry. A write of any other tuple is dropped. Because one write is enough to change the meaning of an encoding, software can switch engines inside a loop. The switch only redirects decode, so no engine loses state. After an accepted write the decoder holds for a fixed number of cycles while the new selection settles.

A build-time option makes the identity read-only. That configuration declares that no custom extensions are present. Writes are then ignored, and every custom-space instruction is flagged illegal.

Supported tuple table: entry i holds vendor id 0x0000_0A00 + i and architecture id 0x8000_0000 + i. Entry i drives engine enable bit i. The custom opcode space is instr[6:0] equal to 7'h0B or 7'h2B.

Sequencer states:
- `SEQ_RUN`: decode is active.
- `SEQ_HOLD`: decode is held and the stall output is high.

Transitions:
- `t_switch`: from RUN to HOLD on an accepted write.
- `t_rearm`: from HOLD to HOLD on an accepted write; this reloads the count.
- `t_tick`: from HOLD to HOLD while the count is above zero; this decrements the count.
- `t_resume`: from HOLD to RUN when the count is zero.

Top module: `idsel_decode_router`

## Requirements
- R1: After reset the identity selects table entry 0. id_rd_vid reads 0x0000_0A00 and id_rd_aid reads 0x8000_0000.
- R2: A write (id_wr_en high) of a tuple in the table takes effect at the clock edge. From the next cycle, the read ports return that tuple.
- R3: A write of a tuple not in the table is ignored, and the read ports keep the previous legal tuple.
- R4: When instr_valid is high, instr[6:0] is 7'h0B or 7'h2B and dec_stall is low, eng_en has exactly bit i set, where i is the selected entry. In that case instr_illegal is low.
- R5: eng_en never has more than one bit set.
- R6: After an accepted write, dec_stall is high for exactly 2 cycles. During those cycles eng_en is zero and instr_illegal is low.
- R7: A rejected write does not raise dec_stall.
- R8: When instr_valid is low, or the opcode is outside the custom space, eng_en is zero and instr_illegal is low.
- R9: With READ_ONLY_ID set, writes are ignored and the read ports stay at entry 0. A valid custom-space instruction then raises instr_illegal with eng_en zero, and dec_stall stays low.
- R10: An instruction presented in the same cycle as an accepted write is routed by the previous selection.
- R11: An accepted write while dec_stall is high reloads the hold. dec_stall then stays high for 2 further cycles counted from that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_wr_en | input | 1 | Identity write strobe |
| id_wr_vid | input | 32 | Vendor id being written |
| id_wr_aid | input | 32 | Architecture id being written |
| id_rd_vid | output | 32 | Selected vendor id |
| id_rd_aid | output | 32 | Selected architecture id |
| instr_valid | input | 1 | Instruction present |
| instr | input | 32 | Instruction word |
| eng_en | output | N_ENG | One-hot engine enables |
| instr_illegal | output | 1 | Custom-space instruction with no enabled engine |
| dec_stall | output | 1 | Decode held during an identity switch |

## Verification
Two functions can meet in one cycle: an identity write and the decode of a custom-space instruction. The bench raises both in the same cycle and checks eng_en before the edge, expecting the engine that was selected before the write. It then expects the hold cycles, and after them the new engine. A second overlap is a fresh accepted write during the hold. For that case the bench counts the stall cycles that follow it, expecting 2 more, and checks that the later write's entry is the one that ends up routed.

// File: rtl/idr_pkg.sv
package idr_pkg;
    typedef enum logic {
        SEQ_RUN  = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_t;

    localparam logic [6:0] OPC_CUST_A = 7'h0B;
    localparam logic [6:0] OPC_CUST_B = 7'h2B;

    function automatic logic [31:0] tbl_vid(input int idx);
        return 32'h0000_0A00 + 32'(idx);
    endfunction

    function automatic logic [31:0] tbl_aid(input int idx);
        return 32'h8000_0000 + 32'(idx);
    endfunction
endpackage

// File: rtl/idr_warl_id.sv
module idr_warl_id #(
    parameter int N_ENG        = 4,
    parameter bit READ_ONLY_ID = 1'b0,
    localparam int SEL_W       = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_vid,
    input  logic [31:0]      wr_aid,
    output logic [SEL_W-1:0] sel,
    output logic             accept,
    output logic [31:0]      rd_vid,
    output logic [31:0]      rd_aid
);
    import idr_pkg::*;

    logic             hit;
    logic [SEL_W-1:0] hit_idx;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < N_ENG; i++) begin
            if (wr_vid == tbl_vid(i) && wr_aid == tbl_aid(i)) begin
                hit     = 1'b1;
                hit_idx = SEL_W'(i);
            end
        end
    end

    assign accept = wr_en && hit && !READ_ONLY_ID;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel <= '0;
        else if (accept) sel <= hit_idx;
    end

    assign rd_vid = tbl_vid(int'(sel));
    assign rd_aid = tbl_aid(int'(sel));

    p_reject_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(sel));
endmodule

// File: rtl/idr_switch_seq.sv
module idr_switch_seq #(
    parameter int STALL_CYC = 2,
    localparam int CNT_W    = (STALL_CYC > 1) ? $clog2(STALL_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic stall
);
    import idr_pkg::*;

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_RUN: begin
                if (accept) begin                 // t_switch
                    state_d = SEQ_HOLD;
                    cnt_d   = CNT_W'(STALL_CYC - 1);
                end
            end
            SEQ_HOLD: begin
                if (accept) begin                 // t_rearm
                    cnt_d = CNT_W'(STALL_CYC - 1);
                end else if (cnt_q == '0) begin   // t_resume
                    state_d = SEQ_RUN;
                end else begin                    // t_tick
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb stall = (state_q == SEQ_HOLD);

    p_stall_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> stall);
    p_no_spurious_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !accept) |=> !stall);
endmodule

// File: rtl/idr_engine_gate.sv
module idr_engine_gate #(
    parameter int N_ENG   = 4,
    localparam int SEL_W  = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             route_ok,
    input  logic [SEL_W-1:0] sel,
    output logic [N_ENG-1:0] eng_en
);
    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        assign eng_en[g] = route_ok && (sel == SEL_W'(g));
    end

    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_en));
endmodule

// File: rtl/idsel_decode_router.sv
module idsel_decode_router #(
    parameter int N_ENG        = 4,
    parameter int STALL_CYC    = 2,
    parameter bit READ_ONLY_ID = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_wr_en,
    input  logic [31:0]      id_wr_vid,
    input  logic [31:0]      id_wr_aid,
    output logic [31:0]      id_rd_vid,
    output logic [31:0]      id_rd_aid,
    input  logic             instr_valid,
    input  logic [31:0]      instr,
    output logic [N_ENG-1:0] eng_en,
    output logic             instr_illegal,
    output logic             dec_stall
);
    import idr_pkg::*;

    localparam int SEL_W = (N_ENG > 1) ? $clog2(N_ENG) : 1;

    logic [SEL_W-1:0] sel;
    logic             accept;
    logic             cust_hit;
    logic             route_ok;

    idr_warl_id #(.N_ENG(N_ENG), .READ_ONLY_ID(READ_ONLY_ID)) u_id (
        .clk(clk), .rst_n(rst_n),
        .wr_en(id_wr_en), .wr_vid(id_wr_vid), .wr_aid(id_wr_aid),
        .sel(sel), .accept(accept),
        .rd_vid(id_rd_vid), .rd_aid(id_rd_aid)
    );

    idr_switch_seq #(.STALL_CYC(STALL_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .stall(dec_stall)
    );

    assign cust_hit = instr_valid &&
                      (instr[6:0] == OPC_CUST_A || instr[6:0] == OPC_CUST_B);
    assign route_ok = cust_hit && !dec_stall && !READ_ONLY_ID;

    idr_engine_gate #(.N_ENG(N_ENG)) u_gate (
        .clk(clk), .rst_n(rst_n), .route_ok(route_ok), .sel(sel), .eng_en(eng_en)
    );

    assign instr_illegal = cust_hit && !dec_stall && (eng_en == '0);

    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stall |-> (eng_en == '0 && !instr_illegal));
    p_ro_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (READ_ONLY_ID && cust_hit) |-> (instr_illegal && eng_en == '0));
    p_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!READ_ONLY_ID && cust_hit && !dec_stall) |-> (eng_en != '0 && !instr_illegal));
endmodule

// File: tb/test_idsel_decode_router.sv
module test_idsel_decode_router;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_vid = '0, wr_aid = '0;
    logic        ivalid = 1'b0;
    logic [31:0] instr = '0;

    logic [31:0]  rd_vid, rd_aid, ro_vid, ro_aid;
    logic [N-1:0] eng_en, ro_en;
    logic         illegal, stall, ro_illegal, ro_stall;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    idsel_decode_router #(.N_ENG(N)) i_idsel_decode_router (
        .clk(clk), .rst_n(rst_n), .id_wr_en(wr_en), .id_wr_vid(wr_vid), .id_wr_aid(wr_aid),
        .id_rd_vid(rd_vid), .id_rd_aid(rd_aid), .instr_valid(ivalid), .instr(instr),
        .eng_en(eng_en), .instr_illegal(illegal), .dec_stall(stall)
    );

    idsel_decode_router #(.N_ENG(N), .READ_ONLY_ID(1'b1)) i_idsel_decode_router_ro (
        .clk(clk), .rst_n(rst_n), .id_wr_en(wr_en), .id_wr_vid(wr_vid), .id_wr_aid(wr_aid),
        .id_rd_vid(ro_vid), .id_rd_aid(ro_aid), .instr_valid(ivalid), .instr(instr),
        .eng_en(ro_en), .instr_illegal(ro_illegal), .dec_stall(ro_stall)
    );

    function automatic logic [31:0] evid(int i); return 32'h0000_0A00 + 32'(i); endfunction
    function automatic logic [31:0] eaid(int i); return 32'h8000_0000 + 32'(i); endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply write at negedge; returns at the following negedge (write consumed)
    task automatic do_write(input logic [31:0] v, input logic [31:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_vid = v; wr_aid = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk(rd_vid == evid(0), "R1", rd_vid, evid(0));
        chk(rd_aid == eaid(0), "R1", rd_aid, eaid(0));
        chk(stall == 1'b0, "R1", stall, 0);
    endtask

    task automatic t_route_each;
        for (int i = N - 1; i >= 0; i--) begin
            do_write(evid(i), eaid(i));
            chk(rd_vid == evid(i) && rd_aid == eaid(i), "R2", {rd_vid, rd_aid}, {evid(i), eaid(i)});
            ivalid = 1'b1; instr = 32'h0000_100B;
            #1;
            chk(stall && eng_en == '0 && !illegal, "R6", {stall, eng_en, illegal}, 64'h1_0_0);
            @(negedge clk);
            chk(stall && eng_en == '0, "R6", {stall, eng_en}, 64'h10);
            @(negedge clk);
            chk(!stall, "R6", stall, 0);
            chk(eng_en == N'(1 << i) && !illegal, "R4", eng_en, 1 << i);
            instr = 32'h0040_002B;
            #1;
            chk(eng_en == N'(1 << i), "R4", eng_en, 1 << i);
            ivalid = 1'b0;
        end
    endtask

    task automatic t_reject;
        do_write(32'h1234_5678, eaid(1));
        chk(rd_vid == evid(0) && rd_aid == eaid(0), "R3", rd_vid, evid(0));
        chk(!stall, "R7", stall, 0);
        do_write(evid(2), eaid(3));
        chk(rd_vid == evid(0), "R3", rd_vid, evid(0));
        @(negedge clk);
        chk(!stall, "R7", stall, 0);
    endtask

    task automatic t_noncustom;
        ivalid = 1'b1; instr = 32'h0000_0033;
        #1;
        chk(eng_en == '0 && !illegal, "R8", {eng_en, illegal}, 0);
        ivalid = 1'b0; instr = 32'h0000_000B;
        #1;
        chk(eng_en == '0 && !illegal, "R8", {eng_en, illegal}, 0);
        chk(ro_en == '0 && !ro_illegal, "R8", {ro_en, ro_illegal}, 0);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        wr_en = 1'b1; wr_vid = evid(3); wr_aid = eaid(3);
        ivalid = 1'b1; instr = 32'h0000_000B;
        #1;
        chk(eng_en == N'(1), "R10", eng_en, 1);
        @(negedge clk);
        wr_en = 1'b0;
        chk(stall && eng_en == '0, "R10", {stall, eng_en}, 64'h10);
        @(negedge clk);
        @(negedge clk);
        chk(eng_en == N'(8), "R10", eng_en, 8);
        ivalid = 1'b0;
    endtask

    task automatic t_restart;
        do_write(evid(1), eaid(1));
        chk(stall, "R11", stall, 1);
        wr_en = 1'b1; wr_vid = evid(2); wr_aid = eaid(2);
        @(negedge clk);
        wr_en = 1'b0;
        chk(stall, "R11", stall, 1);
        @(negedge clk);
        chk(stall, "R11", stall, 1);
        @(negedge clk);
        chk(!stall, "R11", stall, 0);
        ivalid = 1'b1; instr = 32'h0000_002B;
        #1;
        chk(eng_en == N'(4), "R11", eng_en, 4);
        ivalid = 1'b0;
    endtask

    task automatic t_readonly;
        do_write(evid(2), eaid(2));
        chk(ro_vid == evid(0) && ro_aid == eaid(0), "R9", ro_vid, evid(0));
        chk(!ro_stall, "R9", ro_stall, 0);
        ivalid = 1'b1; instr = 32'h0000_000B;
        #1;
        chk(ro_illegal && ro_en == '0, "R9", {ro_illegal, ro_en}, 64'h10);
        ivalid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reject();
        t_noncustom();
        t_route_each();
        t_same_cycle();
        t_restart();
        t_readonly();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule